// File: doc/BRIEF.md
# Trimmed One-Second Divider

This block turns a 32,768 Hz oscillator into a one-pulse-per-second tick and corrects the oscillator's rate digitally. It does not touch the oscillator. Instead, a few seconds in each repeating 64-minute cycle are made longer or shorter by a fixed number of oscillator counts. A slowing trim stretches the second by holding the prescaler. A speeding trim shortens the second by letting the prescaler advance two counts per clock for a while. A sign bit chooses the direction, and a 5-bit magnitude N chooses how many minutes of the cycle carry a trimmed second: the first 2N minutes, each in its second 0.

Alongside the tick, the block drives a 512 Hz square wave for frequency measurement. This wave comes from its own untrimmed counter, so it always shows the raw oscillator rate. The second and minute positions are output for observation. A strobe from the control-register write path restarts the prescaler, the position counters and the test divider together.

Top module: `calib_second_divider`

## Requirements
- R1: After a synchronous active-low reset, tick_o, ft_o, sec_o and min_o are all 0.
- R2: With trim_mag_i = 0, every second lasts exactly OSC_HZ clocks, and tick_o is high for one clock at its end.
- R3: sec_o counts 0 to SEC_PER_MIN-1, and min_o counts 0 to MIN_PER_CYCLE-1. Both advance in the clock in which tick_o rises, and both wrap to 0.
- R4: Only second 0 of minutes m with m < 2*trim_mag_i is trimmed. trim_mag_i = 0 trims no second.
- R5: With trim_sign_i = 0 (slow), a trimmed second lasts OSC_HZ + NEG_BLANK clocks.
- R6: With trim_sign_i = 1 (fast), a trimmed second lasts OSC_HZ - POS_ADD clocks.
- R7: trim_sign_i and trim_mag_i are sampled once, at the start of each second (including the second that starts at reset or at a clear). A change during a second has no effect on the length of that second.
- R8: A clock with ctrl_wr_i = 1 restarts everything. In the next cycle sec_o = 0, min_o = 0, tick_o = 0 and ft_o = 0. The next tick then comes after a full second measured from that clock, with the trim for second 0 of minute 0 applied.
- R9: ft_o starts low after a reset or clear and toggles every FT_DIV/2 clocks, giving a period of FT_DIV clocks. It is never affected by trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| ctrl_wr_i | input | 1 | Control-register write strobe; restarts the divider chain |
| trim_sign_i | input | 1 | Trim direction: 1 speeds the clock up, 0 slows it down |
| trim_mag_i | input | 5 | Trim magnitude N; the first 2N minutes of a cycle are trimmed |
| tick_o | output | 1 | One-clock pulse at the end of each second |
| ft_o | output | 1 | Untrimmed frequency-test square wave |
| sec_o | output | $clog2(SEC_PER_MIN) | Second index within the minute |
| min_o | output | $clog2(MIN_PER_CYCLE) | Minute index within the calibration cycle |

## Verification
The bench measures the length of every second across a full cycle and the wrap into the next one. It does this for no trim, a slow trim of N = 1, a fast trim of N = 2 and a fast trim whose 2N covers the whole shortened cycle. A design that trims the wrong minutes, trims every second of a minute, or uses `<=` instead of `<` on the 2N limit shows a second of the wrong length at a known index.

The trim setting is changed in the middle of a calibration second. A design that reads the setting live would produce a partly trimmed second. The setting is also changed just before a calibration second, which that second must follow.

A clear is issued part-way through a minute. A design that kept the minute, the prescaler or the test-wave phase would show the wrong first-second length or a late ft_o edge. The test wave is also checked clock by clock during a slow-trimmed second, which catches a test divider that shares the trimmed prescaler.

// File: rtl/cds_pkg.sv
// Shared types for the calibrated one-second divider.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cds_pkg;

    // Kind of rate trim that applies to the second in progress
    typedef enum logic [1:0] {
        TRIM_NONE = 2'd0,
        TRIM_SLOW = 2'd1,
        TRIM_FAST = 2'd2
    } trim_mode_t;

endpackage

// File: rtl/cds_position.sv
// Second and minute position counters plus the trim decision for the
// second about to start. The decision is taken from the trim inputs at the
// moment a second starts, which is either a restart (reset or clear) or a
// second boundary. Assumes sec_end is a single-cycle pulse from the
// prescaler and that the prescaler loads mode_load only in those cycles.
module cds_position
    import cds_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    localparam int SEC_W = $clog2(SEC_PER_MIN),
    localparam int MIN_W = $clog2(MIN_PER_CYCLE)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             clr_i,
    input  logic             sec_end_i,
    input  logic             trim_sign_i,
    input  logic [4:0]       trim_mag_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [MIN_W-1:0] min_o,
    output trim_mode_t       mode_load_o
);

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);

    logic             restart;
    logic [SEC_W-1:0] sec_q, sec_nxt, start_sec;
    logic [MIN_W-1:0] min_q, min_nxt, start_min;
    logic [31:0]      min_ext, trim_lim;
    logic             trim_here;

    assign restart = !rst_n_i || clr_i;

    // Position that follows the current second, with wrap at minute and cycle ends
    always_comb begin
        sec_nxt = (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
        if (sec_q == SEC_LAST) begin
            min_nxt = (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
        end else begin
            min_nxt = min_q;
        end
    end

    // Position of the second that starts when the prescaler next loads
    always_comb begin
        if (restart) begin
            start_sec = '0;
            start_min = '0;
        end else begin
            start_sec = sec_nxt;
            start_min = min_nxt;
        end
    end

    // Trim decision: second 0 of a minute below 2N, for N nonzero
    always_comb begin
        min_ext   = 32'(start_min);
        trim_lim  = 32'(trim_mag_i) << 1;
        trim_here = (start_sec == '0) && (trim_mag_i != 5'd0) && (min_ext < trim_lim);
        if (!trim_here) begin
            mode_load_o = TRIM_NONE;
        end else if (trim_sign_i) begin
            mode_load_o = TRIM_FAST;
        end else begin
            mode_load_o = TRIM_SLOW;
        end
    end

    // Position registers: cleared on restart, advanced on each second boundary
    always_ff @(posedge clk_i) begin
        if (restart) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (sec_end_i) begin
            sec_q <= sec_nxt;
            min_q <= min_nxt;
        end
    end

    assign sec_o = sec_q;
    assign min_o = min_q;

endmodule

// File: rtl/cds_prescaler.sv
// Trimmable prescaler from oscillator clocks to one second. In a slow
// second it holds its count for NEG_BLANK clocks. In a fast second it
// steps by two for POS_ADD clocks. Assumes OSC_HZ > 2*POS_ADD, so the
// double-step phase always ends before the terminal count.
module cds_prescaler
    import cds_pkg::*;
#(
    parameter int OSC_HZ    = 32768,
    parameter int NEG_BLANK = 128,
    parameter int POS_ADD   = 256,
    localparam int PRE_W  = $clog2(OSC_HZ),
    localparam int TRIM_MAX = (NEG_BLANK > POS_ADD) ? NEG_BLANK : POS_ADD,
    localparam int TRIM_W = $clog2(TRIM_MAX + 1)
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       clr_i,
    input  trim_mode_t mode_load_i,
    output logic       sec_end_o,
    output logic       tick_o
);

    localparam logic [PRE_W:0] OSC_LIM = (PRE_W + 1)'(OSC_HZ);

    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W:0]    pre_sum;
    logic [1:0]        step;
    logic [TRIM_W-1:0] trim_left_q;
    trim_mode_t        mode_q;
    logic              tick_q;

    // Number of trim clocks belonging to a given mode
    function automatic logic [TRIM_W-1:0] trim_len(input trim_mode_t m);
        case (m)
            TRIM_SLOW: trim_len = TRIM_W'(NEG_BLANK);
            TRIM_FAST: trim_len = TRIM_W'(POS_ADD);
            default:   trim_len = '0;
        endcase
    endfunction

    // Count increment for this clock: held, doubled or normal
    always_comb begin
        step = 2'd1;
        if (trim_left_q != '0) begin
            if (mode_q == TRIM_SLOW) step = 2'd0;
            if (mode_q == TRIM_FAST) step = 2'd2;
        end
        pre_sum   = {1'b0, pre_q} + {{(PRE_W - 1){1'b0}}, step};
        sec_end_o = (pre_sum >= OSC_LIM);
    end

    // Prescaler, trim phase and tick register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || clr_i) begin
            pre_q       <= '0;
            mode_q      <= mode_load_i;
            trim_left_q <= trim_len(mode_load_i);
            tick_q      <= 1'b0;
        end else begin
            tick_q <= sec_end_o;
            if (sec_end_o) begin
                pre_q       <= '0;
                mode_q      <= mode_load_i;
                trim_left_q <= trim_len(mode_load_i);
            end else begin
                pre_q <= pre_sum[PRE_W-1:0];
                if (trim_left_q != '0) trim_left_q <= trim_left_q - 1'b1;
            end
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/cds_ft_div.sv
// Untrimmed divider for the frequency-test square wave. It runs straight
// from the oscillator clock and ignores all trim. Assumes FT_DIV is even
// and at least 2.
module cds_ft_div #(
    parameter int FT_DIV = 64,
    localparam int HALF = FT_DIV / 2,
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic clr_i,
    output logic ft_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ft_q;

    // Half-period counter, toggling the output at each wrap
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || clr_i) begin
            cnt_q <= '0;
            ft_q  <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            ft_q  <= !ft_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ft_o = ft_q;

endmodule

// File: rtl/calib_second_divider.sv
// Top of the calibrated one-second divider. It ties together the trimmable
// prescaler, the position counters that choose the trim, and the untrimmed
// test divider. ctrl_wr_i restarts all three in the same clock. Assumes
// all inputs are synchronous to clk_i.
module calib_second_divider
    import cds_pkg::*;
#(
    parameter int OSC_HZ        = 32768,
    parameter int NEG_BLANK     = 128,
    parameter int POS_ADD       = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int FT_DIV        = 64,
    localparam int SEC_W = $clog2(SEC_PER_MIN),
    localparam int MIN_W = $clog2(MIN_PER_CYCLE)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             ctrl_wr_i,
    input  logic             trim_sign_i,
    input  logic [4:0]       trim_mag_i,
    output logic             tick_o,
    output logic             ft_o,
    output logic [SEC_W-1:0] sec_o,
    output logic [MIN_W-1:0] min_o
);

    logic       sec_end;
    trim_mode_t mode_load;

    cds_position #(
        .SEC_PER_MIN  (SEC_PER_MIN),
        .MIN_PER_CYCLE(MIN_PER_CYCLE)
    ) u_pos (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .clr_i      (ctrl_wr_i),
        .sec_end_i  (sec_end),
        .trim_sign_i(trim_sign_i),
        .trim_mag_i (trim_mag_i),
        .sec_o      (sec_o),
        .min_o      (min_o),
        .mode_load_o(mode_load)
    );

    cds_prescaler #(
        .OSC_HZ   (OSC_HZ),
        .NEG_BLANK(NEG_BLANK),
        .POS_ADD  (POS_ADD)
    ) u_pre (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .clr_i      (ctrl_wr_i),
        .mode_load_i(mode_load),
        .sec_end_o  (sec_end),
        .tick_o     (tick_o)
    );

    cds_ft_div #(
        .FT_DIV(FT_DIV)
    ) u_ft (
        .clk_i  (clk_i),
        .rst_n_i(rst_n_i),
        .clr_i  (ctrl_wr_i),
        .ft_o   (ft_o)
    );

endmodule

// File: rtl/calib_second_divider_chk.sv
// Checker for the calibrated one-second divider. It watches only the top
// ports and keeps its own cycle counters for second length and test-wave
// half period.
module calib_second_divider_chk #(
    parameter int OSC_HZ        = 32768,
    parameter int NEG_BLANK     = 128,
    parameter int POS_ADD       = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int FT_DIV        = 64,
    localparam int SEC_W = $clog2(SEC_PER_MIN),
    localparam int MIN_W = $clog2(MIN_PER_CYCLE)
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             ctrl_wr_i,
    input logic             tick_o,
    input logic             ft_o,
    input logic [SEC_W-1:0] sec_o,
    input logic [MIN_W-1:0] min_o
);

    logic [31:0] sec_gap_q;
    logic [31:0] ft_gap_q;
    logic        ft_d_q;

    // Clocks since the last tick or restart
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || ctrl_wr_i) sec_gap_q <= 32'd0;
        else if (tick_o)           sec_gap_q <= 32'd1;
        else                       sec_gap_q <= sec_gap_q + 32'd1;
    end

    // Clocks since the last test-wave edge or restart
    always_ff @(posedge clk_i) begin
        ft_d_q <= rst_n_i ? ft_o : 1'b0;
        if (!rst_n_i || ctrl_wr_i)  ft_gap_q <= 32'd0;
        else if (ft_o != ft_d_q)    ft_gap_q <= 32'd1;
        else                        ft_gap_q <= ft_gap_q + 32'd1;
    end

    a_r2_tick_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tick_o |=> !tick_o);

    a_r3_sec_range: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (32'(sec_o) < SEC_PER_MIN) && (32'(min_o) < MIN_PER_CYCLE));

    a_r3_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!$stable(sec_o) && !$past(ctrl_wr_i)) |-> tick_o);

    a_r5_r6_len_bounds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tick_o |-> ((sec_gap_q >= 32'(OSC_HZ - POS_ADD)) && (sec_gap_q <= 32'(OSC_HZ + NEG_BLANK))));

    a_r5_gap_limit: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sec_gap_q <= 32'(OSC_HZ + NEG_BLANK));

    a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ctrl_wr_i |=> ((sec_o == '0) && (min_o == '0) && !ft_o && !tick_o));

    a_r9_ft_half: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ((ft_o != ft_d_q) && !$past(ctrl_wr_i)) |-> (ft_gap_q == 32'(FT_DIV / 2)));

endmodule

bind calib_second_divider calib_second_divider_chk #(
    .OSC_HZ       (OSC_HZ),
    .NEG_BLANK    (NEG_BLANK),
    .POS_ADD      (POS_ADD),
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_CYCLE(MIN_PER_CYCLE),
    .FT_DIV       (FT_DIV)
) u_chk (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .ctrl_wr_i(ctrl_wr_i),
    .tick_o   (tick_o),
    .ft_o     (ft_o),
    .sec_o    (sec_o),
    .min_o    (min_o)
);

// File: tb/calib_second_divider_test.sv
// Directed bench for the calibrated one-second divider, run with shrunken
// parameters so that whole calibration cycles fit in a short run.
module calib_second_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int B_OSC = 256;
    localparam int B_NEG = 16;
    localparam int B_POS = 32;
    localparam int B_SPM = 3;
    localparam int B_MPC = 8;
    localparam int B_FT  = 64;
    localparam int SEC_W = $clog2(B_SPM);
    localparam int MIN_W = $clog2(B_MPC);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctrl_wr = 1'b0;
    logic             trim_sign = 1'b0;
    logic [4:0]       trim_mag = 5'd0;
    logic             tick;
    logic             ft;
    logic [SEC_W-1:0] sec;
    logic [MIN_W-1:0] min;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = !clk;

    calib_second_divider #(
        .OSC_HZ(B_OSC), .NEG_BLANK(B_NEG), .POS_ADD(B_POS),
        .SEC_PER_MIN(B_SPM), .MIN_PER_CYCLE(B_MPC), .FT_DIV(B_FT)
    ) uut (
        .clk_i(clk), .rst_n_i(rst_n), .ctrl_wr_i(ctrl_wr),
        .trim_sign_i(trim_sign), .trim_mag_i(trim_mag),
        .tick_o(tick), .ft_o(ft), .sec_o(sec), .min_o(min)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected length of second number j (counted from a restart)
    function automatic int exp_len(input int j, input bit sgn, input int mag);
        int s = j % B_SPM;
        int m = (j / B_SPM) % B_MPC;
        if (s == 0 && mag != 0 && m < 2 * mag) return sgn ? B_OSC - B_POS : B_OSC + B_NEG;
        return B_OSC;
    endfunction

    task automatic do_reset(input bit sgn, input logic [4:0] mag);
        @(negedge clk);
        rst_n = 1'b0; ctrl_wr = 1'b0; trim_sign = sgn; trim_mag = mag;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count clocks until tick is seen; called at a falling edge
    task automatic wait_tick(output int n);
        n = 0;
        for (int k = 0; k < 4 * B_OSC; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (tick) return;
        end
    endtask

    // Measure a run of seconds from a restart and check lengths and positions
    task automatic run_seconds(input bit sgn, input int mag, input int cnt, input string req);
        int n;
        for (int j = 0; j < cnt; j++) begin
            wait_tick(n);
            check(n == exp_len(j, sgn, mag), req, n, exp_len(j, sgn, mag));
            check(int'(sec) == (j + 1) % B_SPM, "R3 sec", int'(sec), (j + 1) % B_SPM);
            check(int'(min) == ((j + 1) / B_SPM) % B_MPC, "R3 min", int'(min), ((j + 1) / B_SPM) % B_MPC);
        end
    endtask

    task automatic t_reset();
        do_reset(1'b0, 5'd0);
        check(!tick && !ft, "R1 tick/ft", int'({tick, ft}), 0);
        check(sec == '0 && min == '0, "R1 position", int'(sec) + int'(min), 0);
    endtask

    task automatic t_no_trim();
        do_reset(1'b0, 5'd0);
        run_seconds(1'b0, 0, B_SPM * B_MPC + B_SPM, "R2 untrimmed length");
    endtask

    task automatic t_slow();
        do_reset(1'b0, 5'd1);
        run_seconds(1'b0, 1, B_SPM * B_MPC + B_SPM + 1, "R5 R4 slow length");
    endtask

    task automatic t_fast();
        do_reset(1'b1, 5'd2);
        run_seconds(1'b1, 2, B_SPM * B_MPC + B_SPM + 1, "R6 R4 fast length");
        do_reset(1'b1, 5'd31);
        run_seconds(1'b1, 31, B_SPM * B_MPC + 1, "R6 R4 full-cycle fast");
    endtask

    // R7: trim setting changes inside and just before a calibration second
    task automatic t_sample();
        int n;
        do_reset(1'b0, 5'd1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        trim_sign = 1'b1; trim_mag = 5'd0;
        wait_tick(n);
        check(n + 5 == B_OSC + B_NEG, "R7 mid-second change ignored", n + 5, B_OSC + B_NEG);
        wait_tick(n);
        check(n == B_OSC, "R7 new setting used", n, B_OSC);
        trim_sign = 1'b0; trim_mag = 5'd1;
        wait_tick(n);
        check(n == B_OSC, "R7 plain second", n, B_OSC);
        wait_tick(n);
        check(n == B_OSC + B_NEG, "R7 setting taken at second start", n, B_OSC + B_NEG);
    endtask

    // R8: clear part-way through a minute
    task automatic t_ctrl_wr();
        int n;
        do_reset(1'b0, 5'd0);
        wait_tick(n);
        repeat (100) @(posedge clk);
        @(negedge clk);
        trim_mag = 5'd1; trim_sign = 1'b0;
        ctrl_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ctrl_wr = 1'b0;
        check(sec == '0 && min == '0, "R8 position cleared", int'(sec) + int'(min), 0);
        check(!ft && !tick, "R8 ft/tick cleared", int'({ft, tick}), 0);
        wait_tick(n);
        check(n == B_OSC + B_NEG, "R8 full trimmed second after clear", n, B_OSC + B_NEG);
    endtask

    // R9: test wave clocked from restart through a slow-trimmed second
    task automatic t_ft();
        int e;
        do_reset(1'b0, 5'd1);
        for (int k = 1; k <= 300; k++) begin
            @(posedge clk);
            @(negedge clk);
            e = (k / (B_FT / 2)) % 2;
            check(int'(ft) == e, "R9 ft wave untrimmed", int'(ft), e);
        end
    endtask

    initial begin
        t_reset();
        t_no_trim();
        t_slow();
        t_fast();
        t_sample();
        t_ctrl_wr();
        t_ft();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule